// File: doc/BRIEF.md
# Fragment Depth Gate

The depth gate sits after fragment generation in a rasterizer. For each fragment it receives the fragment's depth, the depth already held in the buffer for that pixel, and the pixel address. It decides whether the fragment survives. It then raises three strobes that tell the memory side what to do next: write the new depth, fetch a texel, and write the color word. Color and texel words elsewhere in the pipeline are 16-bit 5-6-5 RGB. The gate only steers the accesses and never touches that data.

Three pass modes are offered. The single mode does an ordinary draw. The depth-only mode lays down depth with no shading traffic. The equality mode is the shading pass that follows it: only the surface exactly at the stored depth is shaded, and depth is not rewritten. An optional alternating-frame encoding removes the depth-buffer clear. Even frames keep their values in the lower half of the 24-bit stored range and treat smaller as nearer. Odd frames use the upper half, inverted, and treat larger as nearer. Every value of the new frame therefore beats every leftover value of the previous frame.

Mode, alternating enable and frame parity are plain control pins. They are captured only when `frame_start` pulses, so a change in the middle of a frame waits for the next frame boundary. Fragments flow through a valid/ready handshake, and one registered result stage is all the storage there is. `in_ready` is high whenever the result register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, every output holds its value and no new fragment is taken.

Top module: `frag_depth_gate`

## Requirements
- R1: With the alternating encoding off, the encoded depth is the full 24-bit input. The fragment passes only when the encoded depth is strictly less than the stored depth.
- R2: A failing fragment raises none of the three strobes (depth write, texel fetch, color write).
- R3: In single mode (mode code 0) a passing fragment raises all three strobes.
- R4: In depth-only mode (mode code 1) a passing fragment raises only the depth-write strobe.
- R5: In equality mode (mode code 2) the fragment passes only when the encoded depth equals the stored depth. A pass raises texel fetch and color write, and never depth write.
- R6: On an even alternating frame, the encoded depth is {0, z[22:0]}, so input bit 23 is ignored. The compare is strictly less than.
- R7: On an odd alternating frame, the encoded depth is {1, ~z[22:0]} and the compare is strictly greater than. In the two ordering modes, a stored value whose bit 23 differs from the encoded value's bit 23 always loses to the new fragment.
- R8: `out_z` carries the encoded depth and `out_addr` carries the input address, both valid with the result whether the fragment passes or fails.
- R9: Mode, alternating enable and parity take effect only at a `frame_start` pulse and apply from the next cycle on. Mode code 3 acts as code 0. After reset the gate is in mode 0, with the alternating encoding off and even parity.
- R10: `in_ready` = !`out_valid` || `out_ready`. One fragment is accepted per cycle while this holds. A stalled result holds every output steady.
- R11: After reset `out_valid` is low and all strobes are low. All strobes are low whenever `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Frame boundary strobe that captures the configuration |
| cfg_mode | input | 2 | Pass mode: 0 single, 1 depth-only, 2 equality, 3 as 0 |
| cfg_alt | input | 1 | Alternating-frame depth encoding enable |
| cfg_odd | input | 1 | Frame parity, 1 = odd |
| in_valid | input | 1 | Fragment valid |
| in_ready | output | 1 | Fragment accepted this cycle when high with in_valid |
| in_z | input | Z_W (24) | Fragment depth, 0 nearest |
| in_zbuf | input | Z_W (24) | Depth stored for the pixel |
| in_addr | input | ADDR_W (19) | Pixel address |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Downstream can take the result |
| out_pass | output | 1 | Fragment survived the test |
| out_z | output | Z_W (24) | Encoded depth to store |
| out_addr | output | ADDR_W (19) | Pixel address of the result |
| out_zwr | output | 1 | Depth write request |
| out_texrd | output | 1 | Texel fetch request |
| out_colwr | output | 1 | Color write request |

## Verification
The bench builds the gate with its defaults: a 24-bit stored depth, which gives a 23-bit fragment depth under the alternating scheme, and a 19-bit address. With a 24-bit value the half-range boundary sits at 0x800000, so the vectors can place stored and fragment values right at the edge between the even and odd halves, at the extremes 0x000000 and 0xFFFFFF, and one code apart for the strict and equal compares. The 19-bit address is wide enough to carry a distinct tag on every vector, so a result that comes out in the wrong cycle during a stall is caught.

// File: rtl/dz_pkg.sv
package dz_pkg;

  typedef enum logic [1:0] {
    DZ_SINGLE = 2'd0,
    DZ_PRE    = 2'd1,
    DZ_EQ     = 2'd2,
    DZ_RSVD   = 2'd3
  } dz_mode_e;

  typedef struct packed {
    dz_mode_e mode;
    logic     alt;
    logic     odd;
  } dz_cfg_t;

  typedef struct packed {
    logic pass;
    logic zwr;
    logic tex;
    logic col;
  } dz_ops_t;

  localparam dz_cfg_t DZ_CFG_RESET = '{mode: DZ_SINGLE, alt: 1'b0, odd: 1'b0};

endpackage

// File: rtl/dz_cfg_latch.sv
module dz_cfg_latch
  import dz_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_start,
  input  logic [1:0] mode_in,
  input  logic       alt_in,
  input  logic       odd_in,
  output dz_cfg_t    cfg_q
);

  dz_mode_e mode_norm;

  always_comb begin
    case (mode_in)
      2'd1:    mode_norm = DZ_PRE;
      2'd2:    mode_norm = DZ_EQ;
      default: mode_norm = DZ_SINGLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= DZ_CFG_RESET;
    end else if (frame_start) begin
      cfg_q.mode <= mode_norm;
      cfg_q.alt  <= alt_in;
      cfg_q.odd  <= odd_in;
    end
  end

endmodule

// File: rtl/dz_encode.sv
module dz_encode
  import dz_pkg::*;
#(
  parameter int Z_W = 24
) (
  input  dz_cfg_t          cfg,
  input  logic [Z_W-1:0]   z_in,
  output logic [Z_W-1:0]   z_enc
);

  localparam int FRAG_W = Z_W - 1;

  logic [FRAG_W-1:0] low_bits;
  logic              flip;

  assign flip = cfg.alt & cfg.odd;

  for (genvar b = 0; b < FRAG_W; b++) begin : g_bit
    assign low_bits[b] = z_in[b] ^ flip;
  end

  always_comb begin
    if (!cfg.alt) begin
      z_enc = z_in;
    end else begin
      z_enc = {cfg.odd, low_bits};
    end
  end

endmodule

// File: rtl/dz_decide.sv
module dz_decide
  import dz_pkg::*;
#(
  parameter int Z_W = 24
) (
  input  dz_cfg_t        cfg,
  input  logic [Z_W-1:0] z_enc,
  input  logic [Z_W-1:0] z_stored,
  output dz_ops_t        ops
);

  logic is_lt;
  logic is_gt;
  logic is_eq;
  logic reverse;
  logic pass;

  assign is_lt   = z_enc < z_stored;
  assign is_gt   = z_enc > z_stored;
  assign is_eq   = z_enc == z_stored;
  assign reverse = cfg.alt & cfg.odd;

  always_comb begin
    if (cfg.mode == DZ_EQ) begin
      pass = is_eq;
    end else if (reverse) begin
      pass = is_gt;
    end else begin
      pass = is_lt;
    end
  end

  always_comb begin
    ops.pass = pass;
    case (cfg.mode)
      DZ_PRE: begin
        ops.zwr = pass;
        ops.tex = 1'b0;
        ops.col = 1'b0;
      end
      DZ_EQ: begin
        ops.zwr = 1'b0;
        ops.tex = pass;
        ops.col = pass;
      end
      default: begin
        ops.zwr = pass;
        ops.tex = pass;
        ops.col = pass;
      end
    endcase
  end

endmodule

// File: rtl/dz_out_stage.sv
module dz_out_stage
  import dz_pkg::*;
#(
  parameter int Z_W    = 24,
  parameter int ADDR_W = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  dz_ops_t           ops_in,
  input  logic [Z_W-1:0]    z_in,
  input  logic [ADDR_W-1:0] addr_in,
  output logic              out_valid,
  input  logic              out_ready,
  output dz_ops_t           ops_q,
  output logic [Z_W-1:0]    z_q,
  output logic [ADDR_W-1:0] addr_q
);

  logic load;

  assign in_ready = !out_valid || out_ready;
  assign load     = in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      ops_q     <= '0;
      z_q       <= '0;
      addr_q    <= '0;
    end else if (load) begin
      out_valid <= in_valid;
      if (in_valid) begin
        ops_q  <= ops_in;
        z_q    <= z_in;
        addr_q <= addr_in;
      end else begin
        ops_q  <= '0;
      end
    end
  end

endmodule

// File: rtl/frag_depth_gate.sv
module frag_depth_gate
  import dz_pkg::*;
#(
  parameter int Z_W    = 24,
  parameter int ADDR_W = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic [1:0]        cfg_mode,
  input  logic              cfg_alt,
  input  logic              cfg_odd,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [Z_W-1:0]    in_z,
  input  logic [Z_W-1:0]    in_zbuf,
  input  logic [ADDR_W-1:0] in_addr,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_pass,
  output logic [Z_W-1:0]    out_z,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_zwr,
  output logic              out_texrd,
  output logic              out_colwr
);

  dz_cfg_t        act_cfg;
  logic [Z_W-1:0] z_enc;
  dz_ops_t        ops_now;
  dz_ops_t        ops_q;

  dz_cfg_latch u_cfg (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .mode_in     (cfg_mode),
    .alt_in      (cfg_alt),
    .odd_in      (cfg_odd),
    .cfg_q       (act_cfg)
  );

  dz_encode #(.Z_W(Z_W)) u_enc (
    .cfg   (act_cfg),
    .z_in  (in_z),
    .z_enc (z_enc)
  );

  dz_decide #(.Z_W(Z_W)) u_dec (
    .cfg      (act_cfg),
    .z_enc    (z_enc),
    .z_stored (in_zbuf),
    .ops      (ops_now)
  );

  dz_out_stage #(.Z_W(Z_W), .ADDR_W(ADDR_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .ops_in    (ops_now),
    .z_in      (z_enc),
    .addr_in   (in_addr),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .ops_q     (ops_q),
    .z_q       (out_z),
    .addr_q    (out_addr)
  );

  assign out_pass  = ops_q.pass;
  assign out_zwr   = ops_q.zwr;
  assign out_texrd = ops_q.tex;
  assign out_colwr = ops_q.col;

endmodule

// File: rtl/dz_gate_chk.sv
module dz_gate_chk
  import dz_pkg::*;
#(
  parameter int Z_W    = 24,
  parameter int ADDR_W = 19
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_start,
  input logic              in_valid,
  input logic              in_ready,
  input logic [Z_W-1:0]    in_zbuf,
  input logic              out_valid,
  input logic              out_ready,
  input logic              out_pass,
  input logic [Z_W-1:0]    out_z,
  input logic [ADDR_W-1:0] out_addr,
  input logic              out_zwr,
  input logic              out_texrd,
  input logic              out_colwr,
  input dz_cfg_t           act_cfg
);

  logic fire;
  assign fire = in_valid && in_ready;

  p_fail_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_pass) |-> (!out_zwr && !out_texrd && !out_colwr));

  p_prepass_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && act_cfg.mode == DZ_PRE) |=> (!out_texrd && !out_colwr));

  p_eq_nowrite_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && act_cfg.mode == DZ_EQ) |=> !out_zwr);

  p_odd_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && act_cfg.alt && act_cfg.odd && act_cfg.mode != DZ_EQ && !in_zbuf[Z_W-1])
      |=> out_pass);

  p_even_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && act_cfg.alt && !act_cfg.odd && act_cfg.mode != DZ_EQ && in_zbuf[Z_W-1])
      |=> out_pass);

  p_cfg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(act_cfg));

  p_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready == (!out_valid || out_ready));

  p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_z) && $stable(out_addr)
      && $stable(out_pass) && $stable(out_zwr) && $stable(out_texrd) && $stable(out_colwr)));

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!out_zwr && !out_texrd && !out_colwr));

endmodule

bind frag_depth_gate dz_gate_chk #(.Z_W(Z_W), .ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .frame_start (frame_start),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_zbuf     (in_zbuf),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_pass    (out_pass),
  .out_z       (out_z),
  .out_addr    (out_addr),
  .out_zwr     (out_zwr),
  .out_texrd   (out_texrd),
  .out_colwr   (out_colwr),
  .act_cfg     (act_cfg)
);

// File: tb/frag_depth_gate_tb_top.sv
module frag_depth_gate_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int ZW = 24;
  localparam int AW = 19;

  typedef struct packed {
    logic [1:0]  mode;
    logic        alt;
    logic        odd;
    logic [23:0] zi;
    logic [23:0] zs;
    logic [3:0]  ops;   // {pass, zwr, tex, col}
    logic [23:0] ez;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 1'b0, 1'b0, 24'h000010, 24'h000020, 4'b1111, 24'h000010},
    '{2'd0, 1'b0, 1'b0, 24'h000020, 24'h000020, 4'b0000, 24'h000020},
    '{2'd0, 1'b0, 1'b0, 24'hFFFFFF, 24'h800000, 4'b0000, 24'hFFFFFF},
    '{2'd1, 1'b0, 1'b0, 24'h000005, 24'h000100, 4'b1100, 24'h000005},
    '{2'd1, 1'b0, 1'b0, 24'h000200, 24'h000100, 4'b0000, 24'h000200},
    '{2'd2, 1'b0, 1'b0, 24'h123456, 24'h123456, 4'b1011, 24'h123456},
    '{2'd2, 1'b0, 1'b0, 24'h123457, 24'h123456, 4'b0000, 24'h123457},
    '{2'd0, 1'b1, 1'b0, 24'h000100, 24'h000200, 4'b1111, 24'h000100},
    '{2'd0, 1'b1, 1'b0, 24'h800100, 24'h000050, 4'b0000, 24'h000100},
    '{2'd0, 1'b1, 1'b0, 24'h7FFFFF, 24'h800000, 4'b1111, 24'h7FFFFF},
    '{2'd0, 1'b1, 1'b1, 24'h000000, 24'h7FFFFF, 4'b1111, 24'hFFFFFF},
    '{2'd0, 1'b1, 1'b1, 24'h7FFFFF, 24'h7FFFFF, 4'b1111, 24'h800000},
    '{2'd0, 1'b1, 1'b1, 24'h000010, 24'hFFFFF0, 4'b0000, 24'hFFFFEF},
    '{2'd0, 1'b1, 1'b1, 24'h00000E, 24'hFFFFF0, 4'b1111, 24'hFFFFF1},
    '{2'd1, 1'b1, 1'b1, 24'h000001, 24'hFFFFFD, 4'b1100, 24'hFFFFFE},
    '{2'd2, 1'b1, 1'b1, 24'h000001, 24'hFFFFFE, 4'b1011, 24'hFFFFFE}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          frame_start = 1'b0;
  logic [1:0]    cfg_mode = 2'd0;
  logic          cfg_alt = 1'b0;
  logic          cfg_odd = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [ZW-1:0] in_z = '0;
  logic [ZW-1:0] in_zbuf = '0;
  logic [AW-1:0] in_addr = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic          out_pass;
  logic [ZW-1:0] out_z;
  logic [AW-1:0] out_addr;
  logic          out_zwr;
  logic          out_texrd;
  logic          out_colwr;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  frag_depth_gate #(.Z_W(ZW), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .cfg_mode(cfg_mode), .cfg_alt(cfg_alt), .cfg_odd(cfg_odd),
    .in_valid(in_valid), .in_ready(in_ready), .in_z(in_z), .in_zbuf(in_zbuf),
    .in_addr(in_addr), .out_valid(out_valid), .out_ready(out_ready),
    .out_pass(out_pass), .out_z(out_z), .out_addr(out_addr),
    .out_zwr(out_zwr), .out_texrd(out_texrd), .out_colwr(out_colwr)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic string vec_req(input int i);
    case (i)
      0, 2:        return "R1";
      1:           return "R2";
      3, 4:        return "R4";
      5, 6, 15:    return "R5";
      7, 8, 9:     return "R6";
      14:          return "R4";
      default:     return "R7";
    endcase
  endfunction

  task automatic set_cfg(input logic [1:0] m, input logic a, input logic o, input logic strobe);
    cfg_mode = m; cfg_alt = a; cfg_odd = o; frame_start = strobe;
    @(posedge clk); #1;
    frame_start = 1'b0;
    @(negedge clk);
  endtask

  // drive one fragment at a negedge; result is checked at the following negedge
  task automatic send(input logic [23:0] zi, input logic [23:0] zs, input logic [AW-1:0] a);
    in_valid = 1'b1; in_z = zi; in_zbuf = zs; in_addr = a;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // reset state (R11, R10)
    chk("R11", "out_valid in reset", 32'(out_valid), 32'd0);
    chk("R11", "strobes in reset", {29'd0, out_zwr, out_texrd, out_colwr}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10", "in_ready idle", 32'(in_ready), 32'd1);
    // R9: default config after reset is single mode, alternation off
    send(24'h000001, 24'h000002, 19'h00001);
    chk("R9", "reset cfg strobes", {28'd0, out_pass, out_zwr, out_texrd, out_colwr}, 32'hF);
    @(negedge clk);

    // vector table
    for (int i = 0; i < NV; i++) begin
      set_cfg(VECS[i].mode, VECS[i].alt, VECS[i].odd, 1'b1);
      send(VECS[i].zi, VECS[i].zs, AW'(i + 16));
      chk(vec_req(i), $sformatf("vec%0d valid", i), 32'(out_valid), 32'd1);
      chk(vec_req(i), $sformatf("vec%0d ops", i),
          {28'd0, out_pass, out_zwr, out_texrd, out_colwr}, {28'd0, VECS[i].ops});
      if (!VECS[i].ops[3])
        chk("R2", $sformatf("vec%0d fail strobes", i), {29'd0, out_zwr, out_texrd, out_colwr}, 32'd0);
      if (VECS[i].ops[3] && VECS[i].mode == 2'd0)
        chk("R3", $sformatf("vec%0d single strobes", i), {29'd0, out_zwr, out_texrd, out_colwr}, 32'd7);
      chk("R8", $sformatf("vec%0d z", i), 32'(out_z), 32'(VECS[i].ez));
      chk("R8", $sformatf("vec%0d addr", i), 32'(out_addr), 32'(i + 16));
      @(negedge clk);
      chk("R11", $sformatf("vec%0d idle", i),
          {28'd0, out_valid, out_zwr, out_texrd, out_colwr}, 32'd0);
    end

    // R9: mode change without frame_start is ignored
    set_cfg(2'd0, 1'b0, 1'b0, 1'b1);
    set_cfg(2'd1, 1'b1, 1'b1, 1'b0);
    send(24'h000001, 24'h000002, 19'h00100);
    chk("R9", "midframe ignored", {28'd0, out_pass, out_zwr, out_texrd, out_colwr}, 32'hF);
    chk("R9", "midframe z", 32'(out_z), 32'h000001);
    @(negedge clk);
    set_cfg(2'd1, 1'b0, 1'b0, 1'b1);
    send(24'h000001, 24'h000002, 19'h00101);
    chk("R9", "applied at frame start", {28'd0, out_pass, out_zwr, out_texrd, out_colwr}, 32'hC);
    @(negedge clk);
    set_cfg(2'd3, 1'b0, 1'b0, 1'b1);
    send(24'h000001, 24'h000002, 19'h00102);
    chk("R9", "mode 3 as single", {28'd0, out_pass, out_zwr, out_texrd, out_colwr}, 32'hF);
    @(negedge clk);

    // R10: back-pressure
    out_ready = 1'b0;
    in_valid = 1'b1; in_z = 24'h000001; in_zbuf = 24'h000002; in_addr = 19'h00005;
    @(negedge clk);
    chk("R10", "stall valid", 32'(out_valid), 32'd1);
    chk("R10", "stall in_ready", 32'(in_ready), 32'd0);
    in_z = 24'h000009; in_addr = 19'h00006;
    @(negedge clk);
    @(negedge clk);
    chk("R10", "held z", 32'(out_z), 32'h000001);
    chk("R10", "held addr", 32'(out_addr), 32'h00005);
    chk("R10", "held pass", 32'(out_pass), 32'd1);
    out_ready = 1'b1;
    #1;
    chk("R10", "ready drain", 32'(in_ready), 32'd1);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R10", "second z", 32'(out_z), 32'h000009);
    chk("R10", "second addr", 32'(out_addr), 32'h00006);
    chk("R2", "second fails", {28'd0, out_pass, out_zwr, out_texrd, out_colwr}, 32'd0);
    // R10: back-to-back, one per cycle
    in_valid = 1'b1; in_z = 24'h000001; in_zbuf = 24'h000003; in_addr = 19'h00007;
    @(negedge clk);
    chk("R10", "b2b first", 32'(out_addr), 32'h00007);
    in_z = 24'h000002; in_addr = 19'h00008;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R10", "b2b second", 32'(out_addr), 32'h00008);
    chk("R1", "b2b second pass", 32'(out_pass), 32'd1);
    @(negedge clk);
    chk("R11", "drained", 32'(out_valid), 32'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule